// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an asynchronous 64K x 8 static RAM. The host hands it one read or write request at a time through a valid/ready handshake. The controller then drives the RAM's address, its two chip selects, its output enable, its write enable and the data bus for as many clock cycles as the RAM's minimum timings require. The two chip selects have opposite polarity: one is active low and one is active high. Read data is registered and returned with a one-cycle done pulse, and a write also ends with a done pulse.

Every interval is a whole number of clock cycles. Each is found by rounding a nanosecond minimum up against the `CLK_PERIOD_NS` parameter, using the minimums of the grade that `SPEED_GRADE` selects. The data bus is split into an output value, an output enable and an input value, and the three-state pad belongs to the pad ring. When a write follows a read, a turnaround gap lets the RAM release the bus before the controller drives it.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, `mem_sel_n`=1, `mem_sel`=0, `mem_rd_n`=1, `mem_wr_n`=1, `mem_dq_oe`=0 and `host_done`=0, and `host_ready`=1.
- R2: A request is taken on a clock edge where `host_valid` and `host_ready` are both 1. `host_ready` is 0 from the next cycle until the cycle of that access's done pulse, where it is 1 again. `host_valid` has no effect while `host_ready` is 0.
- R3: A read holds the device selected (`mem_sel_n`=0, `mem_sel`=1), with `mem_rd_n`=0, `mem_wr_n`=1, `mem_dq_oe`=0 and the request address on `mem_addr`. It does so for RD = ceil(tRC/T) cycles, beginning the cycle after acceptance. T is `CLK_PERIOD_NS`.
- R4: `mem_dq_in` is registered at the edge that ends the last read cycle. In the next cycle `host_done`=1 for exactly one cycle, all strobes are inactive, and `host_rdata` holds that value.
- R5: A write first spends SU = max(0, max(ceil(tAW/T), ceil(tCW/T)) - PW) cycles selected, with `mem_wr_n`=1, `mem_rd_n`=1, `mem_dq_oe`=1, the address on `mem_addr` and the write data on `mem_dq_out`.
- R6: Next, `mem_wr_n` is 0 for exactly PW = max(ceil(tWP/T), ceil(tDW/T)) cycles. During these cycles the device is selected, `mem_rd_n`=1, and the address and data are held.
- R7: A write then spends RC = max(ceil(tWC/T), SU+PW) - SU - PW cycles deselected with the bus released. The done pulse follows in the next cycle.
- R8: A write whose preceding completed access was a read waits GP = max(1, ceil(tOHZ/T)) cycles before its first selected cycle, with all strobes inactive and the bus released. A write that follows a write, or is the first access after reset, has no such gap.
- R9: `mem_dq_oe` is never 1 while `mem_rd_n` is 0 or the device is deselected. `mem_wr_n` is 0 only while both selects are active and `mem_rd_n` is 1.
- R10: The nanosecond minimums for `SPEED_GRADE` 0/1/2 are tRC=tWC=70/85/100, tWP=55/60/70, tDW=30/35/40, tAW=tCW=60/70/80 and tOHZ=25/20/20. With the defaults (grade 1, T=8) this gives RD=11, SU=1, PW=8, RC=2 and GP=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Request present |
| host_ready | output | 1 | Controller can take a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Request address |
| host_wdata | input | DATA_W | Write data |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | RAM address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_rd_n | output | 1 | Active-low output enable |
| mem_wr_n | output | 1 | Active-low write enable |
| mem_dq_out | output | DATA_W | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Pad driver enable for the data bus |
| mem_dq_in | input | DATA_W | Data returned from the RAM |

## Verification
The bench's RAM model returns real data only in the last read cycle and returns a decoy value in every earlier one, so a controller that samples early returns the decoy value. While the controller is busy, the bench holds `host_valid` high with a conflicting write to an address that is read back later. A controller that accepts requests while busy therefore corrupts that location or shifts the whole cycle schedule. The bench issues writes directly after reads, after idle gaps, and after other writes, to check that the turnaround gap appears only after a read. It also measures every write-enable pulse, so an off-by-one in the rounding of a grade minimum shows up as a wrong pulse length.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and timing helpers for the SRAM bus controller.
// Assumes the speed grade index is 0, 1 or 2; other values read as grade 2.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_GAP,
        ST_WSET,
        ST_WPUL,
        ST_WREC
    } seq_state_t;

    localparam int P_RC  = 0;
    localparam int P_WC  = 1;
    localparam int P_WP  = 2;
    localparam int P_DW  = 3;
    localparam int P_AW  = 4;
    localparam int P_CW  = 5;
    localparam int P_OHZ = 6;

    // Minimum time in ns of one timing parameter for one grade.
    function automatic int grade_ns(input int grade, input int which);
        int t;
        case (which)
            P_RC, P_WC: t = (grade == 0) ? 70 : (grade == 1) ? 85 : 100;
            P_WP:       t = (grade == 0) ? 55 : (grade == 1) ? 60 : 70;
            P_DW:       t = (grade == 0) ? 30 : (grade == 1) ? 35 : 40;
            P_AW, P_CW: t = (grade == 0) ? 60 : (grade == 1) ? 70 : 80;
            default:    t = (grade == 0) ? 25 : 20;
        endcase
        return t;
    endfunction

    // Integer division rounded up.
    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one phase of an access.
// Loading a value N gives N+1 cycles before zero is reported.
// Assumes every load value fits in CNT_W bits.
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq.sv
// Access sequencer. It walks each request through its phases:
// a read phase, or an optional turnaround gap, write setup, write pulse
// and write recovery. Phase lengths are cycle counts given as parameters.
// Assumes R_CYC >= 1, W_PULSE >= 1 and GAP >= 1.
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int R_CYC   = 11,
    parameter int W_SETUP = 1,
    parameter int W_PULSE = 8,
    parameter int W_REC   = 2,
    parameter int GAP     = 3,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_zero,
    output logic             req_ready,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output seq_state_t       state_q,
    output seq_state_t       state_d,
    output logic             access_done
);

    logic last_rd_q;

    // Next-state and phase-length selection.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    if (!req_write) begin
                        state_d = ST_RD;
                        tmr_val = CNT_W'(R_CYC - 1);
                    end else if (last_rd_q) begin
                        state_d = ST_GAP;
                        tmr_val = CNT_W'(GAP - 1);
                    end else if (W_SETUP > 0) begin
                        state_d = ST_WSET;
                        tmr_val = CNT_W'(W_SETUP - 1);
                    end else begin
                        state_d = ST_WPUL;
                        tmr_val = CNT_W'(W_PULSE - 1);
                    end
                end
            end
            ST_RD: begin
                if (tmr_zero) state_d = ST_IDLE;
            end
            ST_GAP: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (W_SETUP > 0) begin
                        state_d = ST_WSET;
                        tmr_val = CNT_W'(W_SETUP - 1);
                    end else begin
                        state_d = ST_WPUL;
                        tmr_val = CNT_W'(W_PULSE - 1);
                    end
                end
            end
            ST_WSET: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    state_d  = ST_WPUL;
                    tmr_val  = CNT_W'(W_PULSE - 1);
                end
            end
            ST_WPUL: begin
                if (tmr_zero) begin
                    if (W_REC > 0) begin
                        tmr_load = 1'b1;
                        state_d  = ST_WREC;
                        tmr_val  = CNT_W'(W_REC - 1);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_WREC: begin
                if (tmr_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Remembers whether the most recently completed access was a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_rd_q <= 1'b0;
        else if (state_q == ST_RD && tmr_zero)
            last_rd_q <= 1'b1;
        else if (state_q == ST_WPUL && tmr_zero)
            last_rd_q <= 1'b0;
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign access_done = (state_d == ST_IDLE) && (state_q != ST_IDLE);

    // R8: a gap is entered only from idle with a write request pending.
    assert_gap_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> ($past(state_q) == ST_GAP || $past(req_write)));

endmodule

// File: rtl/sram_pin_drv.sv
// Registered pin driver. It turns the sequencer's next state into
// glitch-free strobes, holds the request address and data, and captures
// read data at the end of the read phase.
// Assumes the sequencer only leaves idle on an accepted request.
module sram_pin_drv
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int W_PULSE = 8,
    parameter int GAP     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  seq_state_t        state_q,
    input  seq_state_t        state_d,
    input  logic              access_done,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic sel_d;

    assign sel_d = (state_d == ST_RD) || (state_d == ST_WSET) || (state_d == ST_WPUL);

    // Hold the address and write data of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Register strobes from the next state; all inactive in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_sel_n <= 1'b1;
            mem_sel   <= 1'b0;
            mem_rd_n  <= 1'b1;
            mem_wr_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_sel_n <= !sel_d;
            mem_sel   <= sel_d;
            mem_rd_n  <= (state_d != ST_RD);
            mem_wr_n  <= (state_d != ST_WPUL);
            mem_dq_oe <= (state_d == ST_WSET) || (state_d == ST_WPUL);
        end
    end

    // Capture read data on the edge that closes the read phase; pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= access_done;
            if (state_q == ST_RD && access_done)
                rsp_rdata <= mem_dq_in;
        end
    end

    // ---- checking logic ----
    logic [15:0] we_low_cnt;
    logic [15:0] oe_hi_cnt;

    // Length of the current or just-finished write-enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)              we_low_cnt <= '0;
        else if (!mem_wr_n)      we_low_cnt <= (we_low_cnt == 16'hFFFF) ? we_low_cnt : we_low_cnt + 1'b1;
        else                     we_low_cnt <= '0;
    end

    // Cycles since output enable was last low (saturated after reset).
    always_ff @(posedge clk) begin
        if (!rst_n)                  oe_hi_cnt <= 16'hFFFF;
        else if (!mem_rd_n)          oe_hi_cnt <= '0;
        else if (oe_hi_cnt != 16'hFFFF) oe_hi_cnt <= oe_hi_cnt + 1'b1;
    end

    assert_bus_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_rd_n && !mem_sel_n && mem_sel));

    assert_we_guarded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (mem_rd_n && !mem_sel_n && mem_sel && mem_dq_oe));

    assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (we_low_cnt == 16'(W_PULSE)));

    assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_hi_cnt >= 16'(GAP)));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (mem_sel_n && mem_wr_n && mem_rd_n));

endmodule

// File: rtl/sram_bus_ctrl.sv
// Top of the asynchronous SRAM bus controller. It derives every phase
// length in cycles from the speed grade and the clock period, then
// connects the phase timer, the sequencer and the pin driver.
// Assumes CLK_PERIOD_NS >= 1 and SPEED_GRADE in 0..2.
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int SPEED_GRADE   = 1,
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int RD_CYC  = cdiv(grade_ns(SPEED_GRADE, P_RC), CLK_PERIOD_NS);
    localparam int WP_CYC  = imax(cdiv(grade_ns(SPEED_GRADE, P_WP), CLK_PERIOD_NS),
                                  cdiv(grade_ns(SPEED_GRADE, P_DW), CLK_PERIOD_NS));
    localparam int SEL_CYC = imax(cdiv(grade_ns(SPEED_GRADE, P_AW), CLK_PERIOD_NS),
                                  cdiv(grade_ns(SPEED_GRADE, P_CW), CLK_PERIOD_NS));
    localparam int SU_CYC  = imax(SEL_CYC - WP_CYC, 0);
    localparam int WT_CYC  = imax(cdiv(grade_ns(SPEED_GRADE, P_WC), CLK_PERIOD_NS),
                                  SU_CYC + WP_CYC);
    localparam int REC_CYC = WT_CYC - SU_CYC - WP_CYC;
    localparam int GAP_CYC = imax(1, cdiv(grade_ns(SPEED_GRADE, P_OHZ), CLK_PERIOD_NS));
    localparam int MAX_LEN = imax(imax(RD_CYC, WT_CYC), GAP_CYC);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             access_done;
    seq_state_t       state_q;
    seq_state_t       state_d;
    logic             accept;

    assign accept = host_valid && host_ready;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_seq #(
        .R_CYC   (RD_CYC),
        .W_SETUP (SU_CYC),
        .W_PULSE (WP_CYC),
        .W_REC   (REC_CYC),
        .GAP     (GAP_CYC),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (host_valid),
        .req_write   (host_write),
        .tmr_zero    (tmr_zero),
        .req_ready   (host_ready),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .state_q     (state_q),
        .state_d     (state_d),
        .access_done (access_done)
    );

    sram_pin_drv #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .W_PULSE (WP_CYC),
        .GAP     (GAP_CYC)
    ) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_addr    (host_addr),
        .req_wdata   (host_wdata),
        .state_q     (state_q),
        .state_d     (state_d),
        .access_done (access_done),
        .mem_dq_in   (mem_dq_in),
        .mem_addr    (mem_addr),
        .mem_sel_n   (mem_sel_n),
        .mem_sel     (mem_sel),
        .mem_rd_n    (mem_rd_n),
        .mem_wr_n    (mem_wr_n),
        .mem_dq_out  (mem_dq_out),
        .mem_dq_oe   (mem_dq_oe),
        .rsp_done    (host_done),
        .rsp_rdata   (host_rdata)
    );

    // R10: only three grades exist.
    initial begin
        assert_grade_range_R10: assert (SPEED_GRADE >= 0 && SPEED_GRADE <= 2);
    end

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready) |=> !host_ready);

    assert_ready_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> host_ready);

    assert_read_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd_n) |-> $past(host_valid && host_ready && !host_write));

endmodule

// File: tb/sim_sram_bus_ctrl.sv
`timescale 1ns/1ps
module sim_sram_bus_ctrl;

    // Grade 1 minimums (R10) and the 8 ns clock.
    localparam int T    = 8;
    localparam int TRC  = 85, TWC = 85, TWP = 60, TDW = 35, TAW = 70, TCW = 70, TOHZ = 20;

    function automatic int up(input int ns);
        return (ns + T - 1) / T;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int RD_E  = up(TRC);
    localparam int PW_E  = mx(up(TWP), up(TDW));
    localparam int SU_E  = mx(mx(up(TAW), up(TCW)) - PW_E, 0);
    localparam int RC_E  = mx(up(TWC), SU_E + PW_E) - SU_E - PW_E;
    localparam int GP_E  = mx(1, up(TOHZ));

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_valid, host_write;
    logic [15:0] host_addr;
    logic [7:0]  host_wdata;
    logic        host_ready, host_done;
    logic [7:0]  host_rdata;
    logic [15:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    always #4 clk = ~clk;

    sram_bus_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_done(host_done), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    typedef struct packed {
        logic sel, rd_n, wr_n, oe, rdy, done;
        logic [15:0] a;
        logic [7:0]  d;
        logic [7:0]  rd;
    } exp_t;

    exp_t       eq[$];
    string      tq[$];
    logic [7:0] mem[int];
    bit         rq_w[$];
    logic [15:0] rq_a[$];
    logic [7:0] rq_d[$];
    int         rq_idle[$];

    int  tests = 0, fails = 0, cyc = 0;
    bit  started = 0, finished = 0, last_rd_m = 0, junk_w = 0;
    int  we_run = 0, rd_run = 0, tail = 0;

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'hE7;
    endfunction

    task automatic push(input bit sel, input bit rd_n, input bit wr_n, input bit oe,
                        input logic [15:0] a, input logic [7:0] d, input bit rdy,
                        input bit done, input logic [7:0] rd, input string tag);
        exp_t e;
        e.sel = sel; e.rd_n = rd_n; e.wr_n = wr_n; e.oe = oe;
        e.rdy = rdy; e.done = done; e.a = a; e.d = d; e.rd = rd;
        eq.push_back(e);
        tq.push_back(tag);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d got %h expected %h", tag, cyc, got, exp);
        end
    endtask

    // Per-cycle comparison against the behavioural schedule, plus stimulus.
    always @(negedge clk) begin
        if (started && !finished) begin
            exp_t  e;
            string tag;
            logic [5:0] cg, ce;
            bit ok;
            cyc++;
            if (eq.size() > 0) begin
                e = eq.pop_front(); tag = tq.pop_front();
            end else begin
                e = '0; e.rd_n = 1; e.wr_n = 1; e.rdy = 1; tag = "R2";
            end
            cg = {!mem_sel_n && mem_sel, mem_rd_n, mem_wr_n, mem_dq_oe, host_ready, host_done};
            ce = {e.sel, e.rd_n, e.wr_n, e.oe, e.rdy, e.done};
            ok = (cg == ce) && (mem_sel_n == !mem_sel)
                 && (!e.sel || mem_addr == e.a)
                 && (!e.oe  || mem_dq_out == e.d)
                 && (!e.done || !e.rd_n || !e.rdy || host_rdata == e.rd || tag != "R4");
            chk(ok, tag, {cg, mem_addr, mem_dq_out, host_rdata}, {ce, e.a, e.d, e.rd});

            // R9: bus drive and write strobe guarded.
            chk(!(mem_dq_oe && (!mem_rd_n || mem_sel_n || !mem_sel)) &&
                !(!mem_wr_n && (!mem_rd_n || mem_sel_n || !mem_sel)),
                "R9", {mem_dq_oe, mem_rd_n, mem_wr_n, mem_sel_n, mem_sel},
                {1'b0, 1'b1, 1'b1, 1'b0, 1'b1});

            // RAM model: write while strobe active; R10 pulse length.
            if (!mem_wr_n) begin
                we_run++;
                if (!mem_sel_n && mem_sel && mem_dq_oe) mem[int'(mem_addr)] = mem_dq_out;
            end else if (we_run > 0) begin
                chk(we_run == PW_E, "R10", 64'(we_run), 64'(PW_E));
                we_run = 0;
            end

            // RAM model: data valid only in the final read cycle (R4).
            if (!mem_sel_n && mem_sel && !mem_rd_n) rd_run++;
            else rd_run = 0;
            mem_dq_in = (rd_run == RD_E) ? mem_rd(mem_addr) : 8'hC3;

            // Stimulus.
            if (cyc > 20000) begin
                chk(0, "R2", 64'(cyc), 64'(20000));
                finished = 1;
            end else if (eq.size() != 0) begin
                // Conflicting request while busy must be ignored (R2).
                junk_w = !junk_w;
                host_valid = 1; host_write = junk_w; host_addr = 16'h1234; host_wdata = 8'h00;
            end else if (rq_idle.size() > 0 && rq_idle[0] > 0) begin
                rq_idle[0] = rq_idle[0] - 1;
                host_valid = 0;
            end else if (rq_w.size() > 0) begin
                bit w; logic [15:0] a; logic [7:0] d;
                void'(rq_idle.pop_front());
                w = rq_w.pop_front(); a = rq_a.pop_front(); d = rq_d.pop_front();
                host_valid = 1; host_write = w; host_addr = a; host_wdata = d;
                if (!w) begin
                    for (int i = 0; i < RD_E; i++) push(1, 0, 1, 0, a, 8'h00, 0, 0, 8'h00, "R3");
                    push(0, 1, 1, 0, a, 8'h00, 1, 1, mem_rd(a), "R4");
                    last_rd_m = 1;
                end else begin
                    if (last_rd_m)
                        for (int i = 0; i < GP_E; i++) push(0, 1, 1, 0, a, d, 0, 0, 8'h00, "R8");
                    for (int i = 0; i < SU_E; i++) push(1, 1, 1, 1, a, d, 0, 0, 8'h00, "R5");
                    for (int i = 0; i < PW_E; i++) push(1, 1, 0, 1, a, d, 0, 0, 8'h00, "R6");
                    for (int i = 0; i < RC_E; i++) push(0, 1, 1, 0, a, d, 0, 0, 8'h00, "R7");
                    push(0, 1, 1, 0, a, d, 1, 1, 8'h00, "R7");
                    last_rd_m = 0;
                end
            end else begin
                host_valid = 0;
                tail++;
                if (tail > 4) finished = 1;
            end
        end
    end

    task automatic req(input bit w, input logic [15:0] a, input logic [7:0] d, input int idle);
        rq_w.push_back(w); rq_a.push_back(a); rq_d.push_back(d); rq_idle.push_back(idle);
    endtask

    initial begin
        rst_n = 0; host_valid = 0; host_write = 0; host_addr = '0; host_wdata = '0;
        mem_dq_in = 8'h00;
        req(1, 16'h0000, 8'hA5, 0);   // first write after reset: no gap
        req(1, 16'hFFFF, 8'h3C, 0);   // write after write
        req(0, 16'h0000, 8'h00, 0);
        req(0, 16'hFFFF, 8'h00, 0);   // back-to-back reads
        req(1, 16'h1234, 8'h5A, 0);   // write right after read: gap
        req(0, 16'h1234, 8'h00, 2);
        req(0, 16'h7777, 8'h00, 0);   // unwritten location
        req(1, 16'h7777, 8'h81, 5);   // write after read plus idle: gap still
        req(1, 16'h8000, 8'hFF, 0);
        req(0, 16'h8000, 8'h00, 0);
        req(0, 16'h7777, 8'h00, 3);
        req(0, 16'h1234, 8'h00, 0);
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(mem_sel_n && !mem_sel && mem_rd_n && mem_wr_n && !mem_dq_oe && !host_done && host_ready,
            "R1", {mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_dq_oe, host_done, host_ready},
            {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
        rst_n = 1;
        @(posedge clk);
        started = 1;
        wait (finished);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule